// File: doc/BRIEF.md
# LF Telegram Bit Sequencer

This block plays out a low-frequency data telegram for a bank of antenna channels. Two 56-bit holding buffers form a ping-pong pair: transmission always begins with buffer 1 and alternates to the other buffer whenever that buffer holds fresh data. Each buffer is sent most significant bit first. Every data bit is Manchester coded into two chips. The chip rate comes from a divider on the block clock, with one of two rates selected by a baud bit.

For each of the eight channels, a 2-bit mode chooses low side on, data at 180°, data at 0°, or destroy bits. The block turns that mode into a live drive command and a gain selection for every bit of the telegram. Data channels switch to gain2 inside a window that is counted in bytes. Destroy channels run a short burst at a bit position set in the configuration and return to low side on afterwards. A controller loads the buffers, then either sends an explicit start or lets automatic mode begin as soon as buffer 1 is full. It keeps feeding the idle buffer for as long as the telegram should continue.

Top module: `lfs_telegram_seq`

## Requirements
- R1: Each buffer is sent MSB first. A data bit b appears on `chip_out` as a first chip equal to b, followed by a second chip equal to the inverse of b.
- R2: Each chip lasts LO_DIV clock cycles when `cfg_fast_baud`=0 and HI_DIV cycles when it is 1 (defaults 256 and 128).
- R3: At the end of a buffer, the telegram continues from the other buffer if that buffer holds data. Otherwise it stops, `seq_idle` returns to 1, and the outputs go quiet.
- R4: A write to the buffer currently being sent is ignored. A write to the other buffer is accepted while sending.
- R5: `buf_busy` is 01 while buffer 1 is sent, 10 while buffer 2 is sent, and 00 when idle. `seq_idle` is 1 exactly when `buf_busy` is 00.
- R6: With `cfg_auto_send`=0, a telegram begins only on `start_cmd` while buffer 1 is loaded. A start with buffer 1 empty is ignored.
- R7: With `cfg_auto_send`=1, a telegram begins in the cycle after buffer 1 is written, without any start command.
- R8: Drive codes are 00 = low side on, 01 = data 180°, 10 = data 0°, 11 = destroy. While sending, a channel in mode 01 or 10 drives its own mode. Mode 00 always drives 00.
- R9: Gain codes are 00 = none, 01 = gain1, 10 = gain2, 11 = destroy gain. A data channel shows 10 for telegram bits k with 8·S ≤ k < 8·S+L, where S is `cfg_g2_start_bytes` and L is `cfg_g2_len_bits`. It shows 01 otherwise. L=0 gives gain1 throughout.
- R10: A mode-11 channel drives 11 with gain 11 for telegram bits k with D ≤ k < D+N+1, where D is `cfg_dst_start_bits` raised to at least 2 and N is `cfg_dst_len`. Outside that range it drives 00 with gain 00.
- R11: After reset the block is idle, with `buf_busy`, `chip_out`, `chan_drive` and `chan_gain` all zero.
- R12: Gain1 and gain2 never appear together on the data channels in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_chan_mode | input | 2*NCH | Per-channel mode, channel n at bits 2n+1:2n |
| cfg_fast_baud | input | 1 | 1 selects the fast chip rate |
| cfg_auto_send | input | 1 | 1 starts automatically when buffer 1 fills |
| cfg_g2_start_bytes | input | 6 | Bytes sent at gain1 before the gain2 window |
| cfg_g2_len_bits | input | 7 | Bits sent at gain2, 0 disables gain2 |
| cfg_dst_start_bits | input | 6 | Telegram bits before the destroy burst (minimum 2) |
| cfg_dst_len | input | 2 | Destroy burst length minus one |
| buf_wr | input | 2 | Write strobe per buffer, bit 0 = buffer 1 |
| buf_wdata | input | BUF_W | Data for the buffer write |
| start_cmd | input | 1 | Start request in manual mode |
| chip_out | output | 1 | Manchester chip stream |
| chan_drive | output | 2*NCH | Per-channel drive command |
| chan_gain | output | 2*NCH | Per-channel gain selection |
| buf_busy | output | 2 | Buffer being sent, one-hot |
| seq_idle | output | 1 | No telegram in progress |

## Verification
The checker watches several rules on every cycle. Busy is one-hot and consistent with idle. An idle sequencer keeps all outputs quiet. No channel drives a data phase other than its configured one, and destroy gain appears only with destroy drive. Gain1 and gain2 are never mixed, and in manual mode a transmission never begins without a start request. The bench scenarios are the only way to show the other behaviours: Manchester order and chip length, the exact bit positions of the gain2 window and the destroy burst (including the clamp to 2), hand-over between buffers, rejection of a write to the buffer being sent, and the clean stop when no data is left.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
   typedef enum logic [1:0] {
      DRV_LS_ON   = 2'b00,
      DRV_D180    = 2'b01,
      DRV_D0      = 2'b10,
      DRV_DESTROY = 2'b11
   } drv_e;

   typedef enum logic [1:0] {
      GSEL_NONE = 2'b00,
      GSEL_G1   = 2'b01,
      GSEL_G2   = 2'b10,
      GSEL_DST  = 2'b11
   } gsel_e;

   localparam int unsigned DST_MIN_START = 2;
endpackage

// File: rtl/lfs_chip_timer.sv
module lfs_chip_timer #(
   parameter int LO_DIV = 256,
   parameter int HI_DIV = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic fast,
   output logic tick
);
   localparam int CW = (LO_DIV > 1) ? $clog2(LO_DIV) : 1;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;

   assign lim  = fast ? CW'(HI_DIV - 1) : CW'(LO_DIV - 1);
   assign tick = en && (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!en || tick) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/lfs_buf_pair.sv
module lfs_buf_pair #(
   parameter int W  = 56,
   parameter int IW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    wr,
   input  logic [W-1:0]  wdata,
   input  logic          lock,
   input  logic          lock_sel,
   input  logic          rel,
   input  logic          rel_sel,
   input  logic          rd_sel,
   input  logic [IW-1:0] rd_idx,
   output logic          rd_bit,
   output logic [1:0]    full
);
   logic [W-1:0] mem_q [2];

   for (genvar i = 0; i < 2; i++) begin : g_slot
      logic blocked;
      assign blocked = lock && (lock_sel == 1'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_q[i] <= '0;
            full[i]  <= 1'b0;
         end else if (wr[i] && !blocked) begin
            mem_q[i] <= wdata;
            full[i]  <= 1'b1;
         end else if (rel && (rel_sel == 1'(i))) begin
            full[i]  <= 1'b0;
         end
      end
   end

   assign rd_bit = mem_q[rd_sel][rd_idx];
endmodule

// File: rtl/lfs_bit_window.sv
module lfs_bit_window #(
   parameter int W = 10
) (
   input  logic [W-1:0] pos,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] len,
   output logic         hit
);
   logic [W-1:0] off;
   assign off = pos - lo;
   assign hit = (len != '0) && (pos >= lo) && (off < len);
endmodule

// File: rtl/lfs_chan_drive.sv
module lfs_chan_drive
   import lfs_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       active,
   input  logic       g2_hit,
   input  logic       dst_hit,
   output logic [1:0] drv,
   output logic [1:0] gain
);
   always_comb begin
      drv  = DRV_LS_ON;
      gain = GSEL_NONE;
      if (active) begin
         unique case (drv_e'(mode))
            DRV_D180, DRV_D0: begin
               drv  = mode;
               gain = g2_hit ? GSEL_G2 : GSEL_G1;
            end
            DRV_DESTROY: begin
               if (dst_hit) begin
                  drv  = DRV_DESTROY;
                  gain = GSEL_DST;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/lfs_telegram_seq.sv
module lfs_telegram_seq
   import lfs_pkg::*;
#(
   parameter int NCH         = 8,
   parameter int BUF_W       = 56,
   parameter int LO_DIV      = 256,
   parameter int HI_DIV      = 128,
   parameter int G2_START_W  = 6,
   parameter int G2_LEN_W    = 7,
   parameter int DST_START_W = 6,
   parameter int DST_LEN_W   = 2,
   parameter int TCNT_W      = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [2*NCH-1:0]       cfg_chan_mode,
   input  logic                   cfg_fast_baud,
   input  logic                   cfg_auto_send,
   input  logic [G2_START_W-1:0]  cfg_g2_start_bytes,
   input  logic [G2_LEN_W-1:0]    cfg_g2_len_bits,
   input  logic [DST_START_W-1:0] cfg_dst_start_bits,
   input  logic [DST_LEN_W-1:0]   cfg_dst_len,
   input  logic [1:0]             buf_wr,
   input  logic [BUF_W-1:0]       buf_wdata,
   input  logic                   start_cmd,
   output logic                   chip_out,
   output logic [2*NCH-1:0]       chan_drive,
   output logic [2*NCH-1:0]       chan_gain,
   output logic [1:0]             buf_busy,
   output logic                   seq_idle
);
   localparam int IDX_W = $clog2(BUF_W);

   if (HI_DIV < 2 || LO_DIV < HI_DIV) begin : g_bad_div
      $error("chip dividers must satisfy 2 <= HI_DIV <= LO_DIV");
   end
   if (BUF_W < 2 || NCH < 1) begin : g_bad_size
      $error("buffer width and channel count too small");
   end
   if (TCNT_W <= G2_START_W + 3 || TCNT_W <= G2_LEN_W || TCNT_W <= DST_START_W + 1) begin : g_bad_tcnt
      $error("telegram counter too narrow for the window fields");
   end

   logic              active_q, cur_q, half_q;
   logic [IDX_W-1:0]  bit_q;
   logic [TCNT_W-1:0] tcnt_q;
   logic              tick, rd_bit, go, end_buf;
   logic [1:0]        full;
   logic              g2_hit, dst_hit;
   logic [DST_START_W-1:0] dst_lo;

   assign go      = !active_q && full[0] && (cfg_auto_send || start_cmd);
   assign end_buf = tick && half_q && (bit_q == '0);

   lfs_chip_timer #(.LO_DIV(LO_DIV), .HI_DIV(HI_DIV)) u_timer (
      .clk(clk), .rst_n(rst_n), .en(active_q), .fast(cfg_fast_baud), .tick(tick)
   );

   lfs_buf_pair #(.W(BUF_W), .IW(IDX_W)) u_bufs (
      .clk(clk), .rst_n(rst_n), .wr(buf_wr), .wdata(buf_wdata),
      .lock(active_q), .lock_sel(cur_q),
      .rel(end_buf), .rel_sel(cur_q),
      .rd_sel(cur_q), .rd_idx(bit_q), .rd_bit(rd_bit), .full(full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cur_q    <= 1'b0;
         half_q   <= 1'b0;
         bit_q    <= '0;
         tcnt_q   <= '0;
      end else if (go) begin
         active_q <= 1'b1;
         cur_q    <= 1'b0;
         half_q   <= 1'b0;
         bit_q    <= IDX_W'(BUF_W - 1);
         tcnt_q   <= '0;
      end else if (tick) begin
         half_q <= !half_q;
         if (half_q) begin
            if (tcnt_q != '1) tcnt_q <= tcnt_q + 1'b1;
            if (bit_q == '0) begin
               if (full[!cur_q]) begin
                  cur_q <= !cur_q;
                  bit_q <= IDX_W'(BUF_W - 1);
               end else begin
                  active_q <= 1'b0;
               end
            end else begin
               bit_q <= bit_q - 1'b1;
            end
         end
      end
   end

   assign dst_lo = (cfg_dst_start_bits < DST_START_W'(DST_MIN_START))
                   ? DST_START_W'(DST_MIN_START) : cfg_dst_start_bits;

   lfs_bit_window #(.W(TCNT_W)) u_g2_win (
      .pos(tcnt_q),
      .lo(TCNT_W'({cfg_g2_start_bytes, 3'b000})),
      .len(TCNT_W'(cfg_g2_len_bits)),
      .hit(g2_hit)
   );

   lfs_bit_window #(.W(TCNT_W)) u_dst_win (
      .pos(tcnt_q),
      .lo(TCNT_W'(dst_lo)),
      .len(TCNT_W'(cfg_dst_len) + TCNT_W'(1)),
      .hit(dst_hit)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      lfs_chan_drive u_drv (
         .mode(cfg_chan_mode[2*c +: 2]),
         .active(active_q),
         .g2_hit(g2_hit),
         .dst_hit(dst_hit),
         .drv(chan_drive[2*c +: 2]),
         .gain(chan_gain[2*c +: 2])
      );
   end

   assign chip_out = active_q && (rd_bit ^ half_q);
   assign buf_busy = {active_q && cur_q, active_q && !cur_q};
   assign seq_idle = !active_q;
endmodule

// File: rtl/lfs_telegram_seq_chk.sv
module lfs_telegram_seq_chk #(
   parameter int NCH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2*NCH-1:0] cfg_chan_mode,
   input logic             cfg_auto_send,
   input logic             start_cmd,
   input logic             chip_out,
   input logic [2*NCH-1:0] chan_drive,
   input logic [2*NCH-1:0] chan_gain,
   input logic [1:0]       buf_busy,
   input logic             seq_idle
);
   logic has_g1, has_g2;
   logic [NCH-1:0] dst_mismatch, drv_mismatch;

   always_comb begin
      has_g1 = 1'b0;
      has_g2 = 1'b0;
      for (int c = 0; c < NCH; c++) begin
         if (chan_gain[2*c +: 2] == 2'b01) has_g1 = 1'b1;
         if (chan_gain[2*c +: 2] == 2'b10) has_g2 = 1'b1;
         dst_mismatch[c] = (chan_gain[2*c +: 2] == 2'b11) != (chan_drive[2*c +: 2] == 2'b11);
         drv_mismatch[c] = (chan_drive[2*c +: 2] != 2'b00) &&
                           (chan_drive[2*c +: 2] != cfg_chan_mode[2*c +: 2]);
      end
   end

   // R5
   busy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(buf_busy) && (seq_idle == (buf_busy == 2'b00)));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_idle |-> (chip_out == 1'b0 && chan_drive == '0 && chan_gain == '0));

   // R12
   single_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(has_g1 && has_g2));

   // R10
   dst_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dst_mismatch == '0);

   // R8
   drive_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_mismatch == '0);

   // R6
   manual_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_idle && $past(seq_idle) && !$past(cfg_auto_send)) |-> $past(start_cmd));
endmodule

bind lfs_telegram_seq lfs_telegram_seq_chk #(.NCH(NCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_chan_mode(cfg_chan_mode),
   .cfg_auto_send(cfg_auto_send), .start_cmd(start_cmd),
   .chip_out(chip_out), .chan_drive(chan_drive), .chan_gain(chan_gain),
   .buf_busy(buf_busy), .seq_idle(seq_idle)
);

// File: tb/lfs_telegram_seq_bench.sv
module lfs_telegram_seq_bench;
   localparam int NCH = 8;
   localparam int BW  = 56;
   localparam int LO  = 8;
   localparam int HI  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [2*NCH-1:0] cfg_chan_mode = '0;
   logic             cfg_fast_baud = 1'b0;
   logic             cfg_auto_send = 1'b1;
   logic [5:0]       cfg_g2_start_bytes = '0;
   logic [6:0]       cfg_g2_len_bits = '0;
   logic [5:0]       cfg_dst_start_bits = 6'd2;
   logic [1:0]       cfg_dst_len = '0;
   logic [1:0]       buf_wr = '0;
   logic [BW-1:0]    buf_wdata = '0;
   logic             start_cmd = 1'b0;
   logic             chip_out;
   logic [2*NCH-1:0] chan_drive, chan_gain;
   logic [1:0]       buf_busy;
   logic             seq_idle;

   int n_chk = 0;
   int n_fail = 0;

   lfs_telegram_seq #(.NCH(NCH), .BUF_W(BW), .LO_DIV(LO), .HI_DIV(HI)) u_lfs_telegram_seq (
      .clk(clk), .rst_n(rst_n), .cfg_chan_mode(cfg_chan_mode),
      .cfg_fast_baud(cfg_fast_baud), .cfg_auto_send(cfg_auto_send),
      .cfg_g2_start_bytes(cfg_g2_start_bytes), .cfg_g2_len_bits(cfg_g2_len_bits),
      .cfg_dst_start_bits(cfg_dst_start_bits), .cfg_dst_len(cfg_dst_len),
      .buf_wr(buf_wr), .buf_wdata(buf_wdata), .start_cmd(start_cmd),
      .chip_out(chip_out), .chan_drive(chan_drive), .chan_gain(chan_gain),
      .buf_busy(buf_busy), .seq_idle(seq_idle)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R3 act=running exp=finished");
      report();
   end

   task automatic write_buf(input int idx, input logic [BW-1:0] d);
      @(negedge clk);
      buf_wr = (idx == 0) ? 2'b01 : 2'b10;
      buf_wdata = d;
      @(negedge clk);
      buf_wr = 2'b00;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start_cmd = 1'b1;
      @(negedge clk);
      start_cmd = 1'b0;
   endtask

   function automatic logic [1:0] exp_drv(input logic [1:0] m, input bit din);
      if (m == 2'b01 || m == 2'b10) return m;
      if (m == 2'b11 && din) return 2'b11;
      return 2'b00;
   endfunction

   function automatic logic [1:0] exp_gain(input logic [1:0] m, input bit g2, input bit din);
      if (m == 2'b01 || m == 2'b10) return g2 ? 2'b10 : 2'b01;
      if (m == 2'b11 && din) return 2'b11;
      return 2'b00;
   endfunction

   // entry: at the falling edge just after the edge that accepted the start
   task automatic run_stream(input logic [BW-1:0] d0, input logic [BW-1:0] d1,
                             input int nbuf, input int div, input int s, input int l,
                             input int ds, input int dn, input logic [2*NCH-1:0] modes);
      int dlo;
      dlo = (ds < 2) ? 2 : ds;
      repeat (div / 2) @(posedge clk);
      @(negedge clk);
      for (int b = 0; b < nbuf; b++) begin
         for (int i = BW - 1; i >= 0; i--) begin
            for (int h = 0; h < 2; h++) begin
               logic bv;
               int tg;
               bit g2, din;
               logic [2*NCH-1:0] ed, eg;
               bv = (b == 0) ? d0[i] : d1[i];
               tg = b * BW + (BW - 1 - i);
               chk("R1 R2 chip", 64'(chip_out), 64'((h == 0) ? bv : !bv));
               if (h == 0) begin
                  g2  = (l != 0) && (tg >= 8 * s) && (tg < 8 * s + l);
                  din = (tg >= dlo) && (tg < dlo + dn + 1);
                  for (int c = 0; c < NCH; c++) begin
                     ed[2*c +: 2] = exp_drv(modes[2*c +: 2], din);
                     eg[2*c +: 2] = exp_gain(modes[2*c +: 2], g2, din);
                  end
                  chk("R5 busy", 64'(buf_busy), 64'((b == 0) ? 2'b01 : 2'b10));
                  chk("R8 R10 drive", 64'(chan_drive), 64'(ed));
                  chk("R9 R10 gain", 64'(chan_gain), 64'(eg));
               end
               repeat (div) @(posedge clk);
               @(negedge clk);
            end
         end
      end
      chk("R3 idle after end", 64'(seq_idle), 64'd1);
      chk("R3 quiet outputs", {chip_out, buf_busy, chan_drive, chan_gain}, 64'd0);
   endtask

   initial begin
      logic [BW-1:0] da, db;
      void'($urandom(32'h1F2E_3D4C));
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 idle", 64'(seq_idle), 64'd1);
      chk("R11 busy", 64'(buf_busy), 64'd0);
      chk("R11 outputs", {chip_out, chan_drive, chan_gain}, 64'd0);

      // Directed: auto mode, fast rate, two buffers, reject write to active buffer
      cfg_auto_send = 1'b1;
      cfg_fast_baud = 1'b1;
      cfg_chan_mode = 16'h0039;   // ch0 = 01, ch1 = 10, ch2 = 11
      cfg_g2_start_bytes = 6'd1;
      cfg_g2_len_bits = 7'd5;
      cfg_dst_start_bits = 6'd0;  // clamps to 2
      cfg_dst_len = 2'd3;
      da = {$urandom, $urandom};
      db = {$urandom, $urandom};
      write_buf(1, db);
      repeat (4) @(negedge clk);
      chk("R7 buffer 2 alone does not start", 64'(seq_idle), 64'd1);
      write_buf(0, da);
      @(posedge clk);
      @(negedge clk);
      chk("R7 auto start", 64'(seq_idle), 64'd0);
      fork
         run_stream(da, db, 2, HI, 1, 5, 0, 3, 16'h0039);
         begin
            repeat (30) @(negedge clk);
            write_buf(0, ~da);  // R4: must be ignored, stream check sees old data
         end
      join

      // Directed: manual mode, slow rate, gain2 disabled, destroy at bit 5 only
      cfg_auto_send = 1'b0;
      cfg_fast_baud = 1'b0;
      cfg_chan_mode = 16'hC0A0;
      cfg_g2_len_bits = 7'd0;
      cfg_dst_start_bits = 6'd5;
      cfg_dst_len = 2'd0;
      pulse_start();
      repeat (6) @(negedge clk);
      chk("R6 start with empty buffer ignored", 64'(seq_idle), 64'd1);
      da = {$urandom, $urandom};
      write_buf(0, da);
      repeat (20) @(negedge clk);
      chk("R6 no start without command", 64'(seq_idle), 64'd1);
      pulse_start();
      run_stream(da, '0, 1, LO, 0, 0, 5, 0, 16'hC0A0);

      // Randomized telegrams
      for (int r = 0; r < 4; r++) begin
         int s, l, ds, dn, div;
         logic [2*NCH-1:0] md;
         bit au;
         s  = $urandom % 8;
         l  = $urandom % 24;
         ds = $urandom % 12;
         dn = $urandom % 4;
         md = 16'($urandom);
         au = 1'($urandom);
         cfg_fast_baud = 1'($urandom);
         div = cfg_fast_baud ? HI : LO;
         cfg_auto_send = au;
         cfg_chan_mode = md;
         cfg_g2_start_bytes = 6'(s);
         cfg_g2_len_bits = 7'(l);
         cfg_dst_start_bits = 6'(ds);
         cfg_dst_len = 2'(dn);
         da = {$urandom, $urandom};
         db = {$urandom, $urandom};
         write_buf(1, db);
         write_buf(0, da);
         if (au) begin
            @(posedge clk);
            @(negedge clk);
         end else begin
            pulse_start();
         end
         chk(au ? "R7 random start" : "R6 random start", 64'(seq_idle), 64'd0);
         run_stream(da, db, 2, div, s, l, ds, dn, md);
      end
      report();
   end
endmodule